// File: doc/BRIEF.md
# Display Line Latch with Polarity and Gamma Segment Decode

This block sits between the serial sampling stage and the analog output stage of a column driver for an active-matrix display. While a line is being sampled, a parallel sampling memory fills up with one gray code per output channel. On the rising edge of a line strobe, the whole sampling memory is copied at once into a hold memory. The hold memory keeps driving the outputs for the whole next line, while the sampling memory refills.

On the same strobe edge, two controls are captured. The data-inversion control complements every code of the line. The bank-phase control picks which reference bank feeds the first channel. Neighbouring channels always alternate between the high and low banks, which gives dot inversion. Each held code is then split for a segmented reference ladder. The upper bits choose a pair of neighbouring taps, and the lower bits choose one of eight equal steps inside that pair. Channels are numbered in pin order across the three colour outputs of a pixel, so the colour interleave makes no difference to the numbering.

All timing is synchronous to `clk`. The strobe is sampled each clock, and only its rising transition takes effect. The data-inversion input is expected to be tied low on the board when it is not used.

Top module: `lld_line_latch`

## Requirements
- R1: While `rst` is high, at a clock edge, every held code becomes zero and the captured bank phase becomes low. After reset, every `seg_o` and `frac_o` field is 0, and `bank_o` shows even channels at 0 (low bank) and odd channels at 1 (high bank).
- R2: At the first clock edge where `strobe_i` is seen high after being low (a rising strobe), all channels of `smem_i` are copied at the same time. Channel k occupies bits [6k+5:6k]. The new values are visible right after that edge.
- R3: In any cycle that is not a rising strobe, `bank_o`, `seg_o` and `frac_o` do not change, whatever `smem_i`, `dpol_i` or `opol_i` do. This holds both while the strobe stays low and while it stays high.
- R4: `opol_i` is sampled only at the rising strobe edge. A change of `opol_i` while the strobe stays high has no effect until the next rising strobe.
- R5: Channel k receives bank bit `bank_o[k]`, where 1 means the high reference bank and 0 means the low bank. Adjacent channels always carry opposite bank bits.
- R6: If `opol_i` was 1 at the capturing edge, channel 0 uses the high bank (`bank_o[0]`=1) and channel 1 uses the low bank. If it was 0, the assignment is swapped.
- R7: If `dpol_i` was 0 at the capturing edge, each held code equals the sampled code. If it was 1, each held code is the bitwise complement of the sampled 6-bit code.
- R8: For each channel, `seg_o` field [3k+2:3k] carries the upper 3 bits of the held code. This selects the reference pair at taps 8n and 8(n+1). `frac_o` field [3k+2:3k] carries the lower 3 bits, which select one eighth-step inside that pair.
- R9: A held code of 0 gives segment 0 and fraction 0, which is exactly tap 0. A held code of 63 gives segment 7 and fraction 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smem_i | input | NCH*6 | Parallel sampling memory, channel k at [6k+5:6k] |
| strobe_i | input | 1 | Line strobe; its rising transition loads the hold memory |
| dpol_i | input | 1 | Data inversion: 1 complements every code |
| opol_i | input | 1 | Bank phase: 1 puts channel 0 on the high bank |
| bank_o | output | NCH | Bank per channel, 1 = high reference bank |
| seg_o | output | NCH*3 | Reference-pair (segment) index per channel |
| frac_o | output | NCH*3 | Eighth-step fraction per channel |

## Verification
A corrupted hold register or captured phase shows up at the ports in the first cycle after the strobe edge that loaded it. It then stays visible for the whole line, because nothing rewrites it until the next rising strobe. If the edge detector fires on a level rather than a transition, inputs that change while the strobe stays high leak through within one clock. If the bank parity is inverted or shifted, the alternating pattern breaks at once, or the phase of channel 0 disagrees with the captured control. A slip in the field slicing appears as segment and fraction values swapped or misplaced on the boundary codes 0 and 63.

// File: rtl/lld_pkg.sv
package lld_pkg;
   typedef enum logic {BANK_LOW = 1'b0, BANK_HIGH = 1'b1} bank_e;

   // bank for channel idx given the phase of channel 0
   function automatic bank_e bank_of(input logic first_high, input int unsigned idx);
      logic b;
      b = (idx % 2 == 0) ? first_high : ~first_high;
      return bank_e'(b);
   endfunction
endpackage

// File: rtl/lld_edge.sv
module lld_edge (
   input  logic clk,
   input  logic rst,
   input  logic level_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/lld_hold.sv
module lld_hold #(
   parameter int NCH       = 12,
   parameter int CODE_W    = 6,
   parameter bit STORE_RAW = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load_i,
   input  logic                  dpol_i,
   input  logic                  opol_i,
   input  logic [NCH*CODE_W-1:0] smem_i,
   output logic [NCH*CODE_W-1:0] code_o,
   output logic                  opol_o
);
   localparam int TOTAL_W = NCH * CODE_W;

   logic [TOTAL_W-1:0] hold_q;
   logic               opol_q;

   always_ff @(posedge clk) begin
      if (rst)         opol_q <= 1'b0;
      else if (load_i) opol_q <= opol_i;
   end
   assign opol_o = opol_q;

   if (STORE_RAW) begin : g_raw
      // keep raw codes, apply inversion on the read side
      logic dpol_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            hold_q <= '0;
            dpol_q <= 1'b0;
         end else if (load_i) begin
            hold_q <= smem_i;
            dpol_q <= dpol_i;
         end
      end
      assign code_o = hold_q ^ {TOTAL_W{dpol_q}};
   end else begin : g_pre
      // apply inversion before storage, one lane per channel
      logic [TOTAL_W-1:0] fixed;
      for (genvar c = 0; c < NCH; c++) begin : g_lane
         assign fixed[c*CODE_W +: CODE_W] =
            smem_i[c*CODE_W +: CODE_W] ^ {CODE_W{dpol_i}};
      end
      always_ff @(posedge clk) begin
         if (rst)         hold_q <= '0;
         else if (load_i) hold_q <= fixed;
      end
      assign code_o = hold_q;
   end
endmodule

// File: rtl/lld_decode.sv
module lld_decode #(
   parameter int NCH    = 12,
   parameter int CODE_W = 6,
   parameter int FRAC_W = 3
) (
   input  logic [NCH*CODE_W-1:0]          code_i,
   input  logic                           opol_i,
   output logic [NCH-1:0]                 bank_o,
   output logic [NCH*(CODE_W-FRAC_W)-1:0] seg_o,
   output logic [NCH*FRAC_W-1:0]          frac_o
);
   import lld_pkg::*;
   localparam int SEG_W = CODE_W - FRAC_W;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [CODE_W-1:0] code;
      assign code = code_i[c*CODE_W +: CODE_W];
      assign seg_o[c*SEG_W +: SEG_W]    = code[CODE_W-1:FRAC_W];
      assign frac_o[c*FRAC_W +: FRAC_W] = code[FRAC_W-1:0];
      assign bank_o[c] = bank_of(opol_i, c);
   end
endmodule

// File: rtl/lld_line_latch.sv
module lld_line_latch #(
   parameter int NCH       = 12,
   parameter int CODE_W    = 6,
   parameter int FRAC_W    = 3,
   parameter bit STORE_RAW = 1'b0,
   localparam int SEG_W    = CODE_W - FRAC_W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NCH*CODE_W-1:0]  smem_i,
   input  logic                   strobe_i,
   input  logic                   dpol_i,
   input  logic                   opol_i,
   output logic [NCH-1:0]         bank_o,
   output logic [NCH*SEG_W-1:0]   seg_o,
   output logic [NCH*FRAC_W-1:0]  frac_o
);
   if (NCH < 2)          begin : g_bad_nch  $error("NCH must be at least 2"); end
   if (FRAC_W < 1)       begin : g_bad_frac $error("FRAC_W must be at least 1"); end
   if (CODE_W <= FRAC_W) begin : g_bad_code $error("CODE_W must exceed FRAC_W"); end

   logic                  load;
   logic                  opol_held;
   logic [NCH*CODE_W-1:0] code;

   lld_edge u_edge (
      .clk     (clk),
      .rst     (rst),
      .level_i (strobe_i),
      .rise_o  (load)
   );

   lld_hold #(.NCH(NCH), .CODE_W(CODE_W), .STORE_RAW(STORE_RAW)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .load_i (load),
      .dpol_i (dpol_i),
      .opol_i (opol_i),
      .smem_i (smem_i),
      .code_o (code),
      .opol_o (opol_held)
   );

   lld_decode #(.NCH(NCH), .CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_dec (
      .code_i (code),
      .opol_i (opol_held),
      .bank_o (bank_o),
      .seg_o  (seg_o),
      .frac_o (frac_o)
   );
endmodule

// File: rtl/lld_line_latch_chk.sv
module lld_line_latch_chk #(
   parameter int NCH    = 12,
   parameter int CODE_W = 6,
   parameter int FRAC_W = 3,
   localparam int SEG_W = CODE_W - FRAC_W
) (
   input logic                  clk,
   input logic                  rst,
   input logic [NCH*CODE_W-1:0] smem_i,
   input logic                  strobe_i,
   input logic                  dpol_i,
   input logic                  opol_i,
   input logic [NCH-1:0]        bank_o,
   input logic [NCH*SEG_W-1:0]  seg_o,
   input logic [NCH*FRAC_W-1:0] frac_o
);
   logic           seen_q;
   logic           rise;
   logic [NCH-1:0] alt;

   always_ff @(posedge clk) begin
      if (rst) seen_q <= 1'b0;
      else     seen_q <= strobe_i;
   end
   assign rise = strobe_i && !seen_q;

   always_comb begin
      for (int i = 0; i < NCH; i++) alt[i] = i[0];
   end

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (seg_o == '0 && frac_o == '0 && bank_o[0] == 1'b0));

   // R3
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !rise |=> ($stable(bank_o) && $stable(seg_o) && $stable(frac_o)));

   // R5
   bank_alternate_chk: assert property (@(posedge clk) disable iff (rst)
      (bank_o == alt) || (bank_o == ~alt));

   // R6
   bank_phase_chk: assert property (@(posedge clk) disable iff (rst)
      rise |=> (bank_o[0] == $past(opol_i)));

   // R7
   first_code_chk: assert property (@(posedge clk) disable iff (rst)
      rise |=> ({seg_o[SEG_W-1:0], frac_o[FRAC_W-1:0]} ==
                ($past(smem_i[CODE_W-1:0]) ^ {CODE_W{$past(dpol_i)}})));
endmodule

bind lld_line_latch lld_line_latch_chk #(.NCH(NCH), .CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .smem_i   (smem_i),
   .strobe_i (strobe_i),
   .dpol_i   (dpol_i),
   .opol_i   (opol_i),
   .bank_o   (bank_o),
   .seg_o    (seg_o),
   .frac_o   (frac_o)
);

// File: tb/lld_line_latch_bench.sv
module lld_line_latch_bench;
   localparam int NCH = 12;
   localparam int CW  = 6;
   localparam int FW  = 3;
   localparam int SW  = CW - FW;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NCH*CW-1:0] smem = '0;
   logic              strobe = 1'b0;
   logic              dpol = 1'b0;
   logic              opol = 1'b0;
   logic [NCH-1:0]    bank;
   logic [NCH*SW-1:0] seg;
   logic [NCH*FW-1:0] frac;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   lld_line_latch #(.NCH(NCH), .CODE_W(CW), .FRAC_W(FW)) u_lld_line_latch (
      .clk(clk), .rst(rst), .smem_i(smem), .strobe_i(strobe),
      .dpol_i(dpol), .opol_i(opol), .bank_o(bank), .seg_o(seg), .frac_o(frac)
   );

   // expected outputs for a line (data, inversion, phase)
   task automatic check_line(input string req, input logic [NCH*CW-1:0] d,
                             input logic inv, input logic ph);
      logic [NCH-1:0]    eb;
      logic [NCH*SW-1:0] es;
      logic [NCH*FW-1:0] ef;
      for (int k = 0; k < NCH; k++) begin
         logic [CW-1:0] c;
         c = d[k*CW +: CW];
         if (inv) c = ~c;
         es[k*SW +: SW] = c[CW-1:FW];
         ef[k*FW +: FW] = c[FW-1:0];
         eb[k] = (k % 2 == 0) ? ph : ~ph;
      end
      checks++;
      if (bank !== eb) begin
         failures++;
         $display("FAIL %s bank actual=%h expected=%h", req, bank, eb);
      end
      checks++;
      if (seg !== es) begin
         failures++;
         $display("FAIL %s seg actual=%h expected=%h", req, seg, es);
      end
      checks++;
      if (frac !== ef) begin
         failures++;
         $display("FAIL %s frac actual=%h expected=%h", req, frac, ef);
      end
   endtask

   function automatic logic [NCH*CW-1:0] pattern(input int seed);
      logic [NCH*CW-1:0] v;
      for (int k = 0; k < NCH; k++) v[k*CW +: CW] = CW'((seed * 7 + k * 13 + 5) & 63);
      return v;
   endfunction

   // one strobe pulse of one clock
   task automatic pulse_line(input logic [NCH*CW-1:0] d, input logic inv, input logic ph);
      @(negedge clk);
      smem = d; dpol = inv; opol = ph; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
   endtask

   task automatic t_reset();
      check_line("R1", '0, 1'b0, 1'b0);
   endtask

   task automatic t_basic();
      // R2 R8: parallel capture and field split, phase high
      pulse_line(pattern(1), 1'b0, 1'b1);
      check_line("R2", pattern(1), 1'b0, 1'b1);
      // R6: phase low swaps bank assignment (R5 alternation checked too)
      pulse_line(pattern(2), 1'b0, 1'b0);
      check_line("R6", pattern(2), 1'b0, 1'b0);
      pulse_line(pattern(3), 1'b0, 1'b1);
      check_line("R5", pattern(3), 1'b0, 1'b1);
   endtask

   task automatic t_invert();
      // R7: complement of every code
      pulse_line(pattern(4), 1'b1, 1'b0);
      check_line("R7", pattern(4), 1'b1, 1'b0);
      pulse_line(pattern(5), 1'b0, 1'b0);
      check_line("R7", pattern(5), 1'b0, 1'b0);
   endtask

   task automatic t_stable();
      logic [NCH*CW-1:0] held;
      held = pattern(6);
      pulse_line(held, 1'b0, 1'b1);
      // R3: strobe low, inputs wander
      for (int n = 0; n < 4; n++) begin
         @(negedge clk);
         smem = pattern(20 + n); dpol = n[0]; opol = ~n[0];
      end
      @(negedge clk);
      check_line("R3", held, 1'b0, 1'b1);
      // R4: strobe stays high, later phase/data changes ignored
      smem = pattern(7); dpol = 1'b0; opol = 1'b0; strobe = 1'b1;
      @(negedge clk);
      opol = 1'b1; dpol = 1'b1; smem = pattern(8);
      @(negedge clk);
      @(negedge clk);
      check_line("R4", pattern(7), 1'b0, 1'b0);
      strobe = 1'b0;
      @(negedge clk);
      check_line("R3", pattern(7), 1'b0, 1'b0);
   endtask

   task automatic t_bounds();
      // R9: code 0 and code 63, including inversion turning 0 into 63
      pulse_line('0, 1'b0, 1'b1);
      check_line("R9", '0, 1'b0, 1'b1);
      pulse_line('0, 1'b1, 1'b1);
      check_line("R9", '0, 1'b1, 1'b1);
      pulse_line('1, 1'b0, 1'b0);
      check_line("R9", '1, 1'b0, 1'b0);
      // R2: back-to-back strobes each load
      pulse_line(pattern(9), 1'b0, 1'b1);
      pulse_line(pattern(10), 1'b1, 1'b0);
      check_line("R2", pattern(10), 1'b1, 1'b0);
   endtask

   // R1: reset mid-run clears state
   task automatic t_rereset();
      pulse_line(pattern(11), 1'b1, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check_line("R1", '0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      #(4 * 20000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_basic();
      t_invert();
      t_stable();
      t_bounds();
      t_rereset();
      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule